// File: doc/BRIEF.md
# H-Bridge Chopping Gate Controller

This block sequences the four gate enables of a full H-bridge that drives one brushed DC motor. Two direction inputs select coast, forward, reverse or brake. An active-low sleep input parks the bridge. Two digital fault inputs, over-temperature and supply undervoltage, switch every gate off. A current-trip input comes from an external sense comparator. When it fires, the active high-side switch is chopped off for a fixed off-time. During that off-time the load current recirculates through both low-side switches (synchronous slow decay). Analog sensing, gate drive and the power devices sit outside the block.

The controller is one enumerated state machine: SLEEP, WAKE, FAULT, IDLE, DEAD, DRIVE, CHOP_DEAD, CHOP_SR, CHOP_REC and BRAKE. The transitions are:
- Any state goes to SLEEP when sleep is asserted, and to FAULT when a fault input is high.
- SLEEP goes to WAKE on release. WAKE goes to IDLE when the wake timer expires. FAULT goes to IDLE once the fault clears.
- IDLE goes to DEAD on a non-coast command.
- DEAD goes to DRIVE, BRAKE or IDLE when its timer expires. It reloads its timer if the command changes again.
- DRIVE goes to CHOP_DEAD on an accepted trip. The chop sequence then runs CHOP_DEAD, CHOP_SR, CHOP_REC and back to DRIVE, each step on its timer.
- DRIVE, BRAKE and the three chop states all go to DEAD on a command change.

One phase timer times the WAKE, DEAD and chop states. A separate blanking timer is reloaded every time DRIVE is entered. The off-time, blanking time, crossover delay and wake delay are given in nanoseconds. They are converted to clock cycles from the `CLK_HZ` parameter.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: The command is decoded from {dir_a_i, dir_b_i}. 00 is coast, with all gates off. 10 is forward: high-side A and low-side B on, gate vector {hs_a, ls_a, hs_b, ls_b} = 1001. 01 is reverse: 0110. 11 is brake, with both low sides on: 0101. At most one high-side gate is ever on.
- R2: The direction and sleep inputs each pass through a two-flop synchronizer. A direction change made before rising edge E1 first alters the gates after edge E3. From DRIVE, BRAKE or a chop state, a command change passes through an all-off interval of exactly DEAD_CYC cycles before the new command's gates turn on.
- R3: No leg ever has its high-side and low-side gates on together.
- R4: A trip accepted in DRIVE turns the active high-side gate off on the next edge. The gate stays off for exactly OFF_CYC cycles and then turns back on with the same diagonal.
- R5: During the off-time, the low-side gate of the chopped leg turns on DEAD_CYC cycles after its high side turns off, and it stays on for OFF_CYC - 2*DEAD_CYC cycles. It then turns off DEAD_CYC cycles before the high side returns. The opposite low side stays on throughout. Any low-side gate rising is preceded by at least DEAD_CYC cycles with its paired high side off, and the reverse also holds.
- R6: A trip is ignored during the first BLANK_CYC cycles of every DRIVE interval. With the trip held high, each high-side on-interval lasts exactly BLANK_CYC cycles.
- R7: In brake, the trip input has no effect on the gates.
- R8: A low level on sleep_n_i turns all gates off after the third rising edge and holds them off while it stays low, whatever the commands are.
- R9: After sleep_n_i rises, commands are ignored for WAKE_CYC cycles. With forward already applied, high-side A first turns on WAKE_CYC + DEAD_CYC + 3 cycles after release.
- R10: A high level on therm_flt_i or uv_flt_i turns all gates off on the next edge. Once both clear, driving resumes through the DEAD interval.
- R11: Under reset, and after reset until sleep is released, all gates are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| dir_a_i | input | 1 | Direction input A (asynchronous) |
| dir_b_i | input | 1 | Direction input B (asynchronous) |
| sleep_n_i | input | 1 | Active-low sleep request (asynchronous) |
| trip_i | input | 1 | Current-trip comparator output, synchronous |
| therm_flt_i | input | 1 | Over-temperature fault, high disables |
| uv_flt_i | input | 1 | Supply undervoltage fault, high disables |
| gate_hs_a_o | output | 1 | High-side gate enable, leg A |
| gate_ls_a_o | output | 1 | Low-side gate enable, leg A |
| gate_hs_b_o | output | 1 | High-side gate enable, leg B |
| gate_ls_b_o | output | 1 | Low-side gate enable, leg B |

## Verification
A wrong state or timer value shows up at the gate pins within one chop period. A miscounted phase timer changes the measured off-time or the crossover gap at the first trip. A stale blanking count shortens or stretches the on-interval under a held trip. A state that drives the wrong leg is caught at the first edge, because a leg with both gates on trips the exclusivity check at once. A missed dead interval on a direction reversal appears as a zero-length all-off gap on the next command change.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [1:0] {
        CMD_COAST = 2'b00,
        CMD_FWD   = 2'b01,
        CMD_REV   = 2'b10,
        CMD_BRAKE = 2'b11
    } cmd_e;

    typedef enum logic [3:0] {
        ST_SLEEP,
        ST_WAKE,
        ST_FAULT,
        ST_IDLE,
        ST_DEAD,
        ST_DRIVE,
        ST_CHOP_DEAD,
        ST_CHOP_SR,
        ST_CHOP_REC,
        ST_BRAKE
    } state_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gates_t;

    function automatic int ns_to_cyc(input int clk_hz, input int ns);
        int c;
        c = ((clk_hz / 1_000_000) * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/hbc_decode.sv
module hbc_decode
    import hbc_pkg::*;
(
    input  logic dir_a_i,
    input  logic dir_b_i,
    output cmd_e cmd_o
);
    always_comb begin
        unique case ({dir_b_i, dir_a_i})
            2'b00:   cmd_o = CMD_COAST;
            2'b01:   cmd_o = CMD_FWD;
            2'b10:   cmd_o = CMD_REV;
            default: cmd_o = CMD_BRAKE;
        endcase
    end
endmodule

// File: rtl/hbc_timer.sv
module hbc_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
    import hbc_pkg::*;
#(
    parameter int CLK_HZ   = 200_000_000,
    parameter int OFF_NS   = 3000,
    parameter int BLANK_NS = 3000,
    parameter int DEAD_NS  = 425,
    parameter int WAKE_NS  = 1_500_000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic sleep_n_i,
    input  logic trip_i,
    input  logic therm_flt_i,
    input  logic uv_flt_i,
    output logic gate_hs_a_o,
    output logic gate_ls_a_o,
    output logic gate_hs_b_o,
    output logic gate_ls_b_o
);
    localparam int OFF_RAW   = ns_to_cyc(CLK_HZ, OFF_NS);
    localparam int BLANK_CYC = ns_to_cyc(CLK_HZ, BLANK_NS);
    localparam int DEAD_CYC  = ns_to_cyc(CLK_HZ, DEAD_NS);
    localparam int WAKE_CYC  = ns_to_cyc(CLK_HZ, WAKE_NS);
    // Off-time must hold two crossover gaps and at least one SR cycle.
    localparam int OFF_CYC   = (OFF_RAW < 2 * DEAD_CYC + 1) ? 2 * DEAD_CYC + 1 : OFF_RAW;
    localparam int SR_CYC    = OFF_CYC - 2 * DEAD_CYC;
    localparam int PH_MAX    = (WAKE_CYC > OFF_CYC) ? WAKE_CYC : OFF_CYC;
    localparam int PH_W      = $clog2(PH_MAX + 1);
    localparam int BL_W      = $clog2(BLANK_CYC + 1);

    // Input conditioning
    logic [2:0] sync_q;
    logic       sleep_s;
    cmd_e       cmd_s;

    hbc_sync #(.W(3)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     ({sleep_n_i, dir_b_i, dir_a_i}),
        .q_o     (sync_q)
    );

    assign sleep_s = sync_q[2];

    hbc_decode u_dec (
        .dir_a_i (sync_q[0]),
        .dir_b_i (sync_q[1]),
        .cmd_o   (cmd_s)
    );

    // Timers
    logic            ph_load;
    logic [PH_W-1:0] ph_val;
    logic            ph_zero;
    logic            bl_load;
    logic            bl_zero;

    hbc_timer #(.W(PH_W)) u_phase_tmr (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (ph_load),
        .load_val_i (ph_val),
        .zero_o     (ph_zero)
    );

    hbc_timer #(.W(BL_W)) u_blank_tmr (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (bl_load),
        .load_val_i (BL_W'(BLANK_CYC - 1)),
        .zero_o     (bl_zero)
    );

    // State register
    state_e state_q, state_d;
    cmd_e   cmd_q, cmd_d;
    logic   fault;
    logic   cmd_chg;

    assign fault   = therm_flt_i | uv_flt_i;
    assign cmd_chg = (cmd_s != cmd_q);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= ST_SLEEP;
            cmd_q   <= CMD_COAST;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        ph_load = 1'b0;
        ph_val  = '0;
        bl_load = 1'b0;

        if (!sleep_s) begin
            state_d = ST_SLEEP;
            cmd_d   = CMD_COAST;
        end else if (fault) begin
            state_d = ST_FAULT;
            cmd_d   = CMD_COAST;
        end else begin
            unique case (state_q)
                ST_SLEEP: begin
                    state_d = ST_WAKE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(WAKE_CYC - 1);
                end
                ST_WAKE: begin
                    if (ph_zero) state_d = ST_IDLE;
                end
                ST_FAULT: begin
                    state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (cmd_s != CMD_COAST) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end
                end
                ST_DEAD: begin
                    if (cmd_chg) begin
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end else if (ph_zero) begin
                        unique case (cmd_q)
                            CMD_COAST: state_d = ST_IDLE;
                            CMD_BRAKE: state_d = ST_BRAKE;
                            default: begin
                                state_d = ST_DRIVE;
                                bl_load = 1'b1;
                            end
                        endcase
                    end
                end
                ST_DRIVE: begin
                    if (cmd_chg) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end else if (trip_i && bl_zero) begin
                        state_d = ST_CHOP_DEAD;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end
                end
                ST_CHOP_DEAD: begin
                    if (cmd_chg) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end else if (ph_zero) begin
                        state_d = ST_CHOP_SR;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(SR_CYC - 1);
                    end
                end
                ST_CHOP_SR: begin
                    if (cmd_chg) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end else if (ph_zero) begin
                        state_d = ST_CHOP_REC;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end
                end
                ST_CHOP_REC: begin
                    if (cmd_chg) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end else if (ph_zero) begin
                        state_d = ST_DRIVE;
                        bl_load = 1'b1;
                    end
                end
                ST_BRAKE: begin
                    if (cmd_chg) begin
                        state_d = ST_DEAD;
                        cmd_d   = cmd_s;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(DEAD_CYC - 1);
                    end
                end
                default: begin
                    state_d = ST_SLEEP;
                    cmd_d   = CMD_COAST;
                end
            endcase
        end
    end

    // Output decode
    gates_t gates;

    always_comb begin
        gates = '0;
        unique case (state_q)
            ST_DRIVE: begin
                if (cmd_q == CMD_FWD) begin
                    gates.hs_a = 1'b1;
                    gates.ls_b = 1'b1;
                end else if (cmd_q == CMD_REV) begin
                    gates.hs_b = 1'b1;
                    gates.ls_a = 1'b1;
                end
            end
            ST_CHOP_DEAD, ST_CHOP_REC: begin
                if (cmd_q == CMD_FWD) gates.ls_b = 1'b1;
                else if (cmd_q == CMD_REV) gates.ls_a = 1'b1;
            end
            ST_CHOP_SR, ST_BRAKE: begin
                gates.ls_a = 1'b1;
                gates.ls_b = 1'b1;
            end
            default: gates = '0;
        endcase
    end

    assign gate_hs_a_o = gates.hs_a;
    assign gate_ls_a_o = gates.ls_a;
    assign gate_hs_b_o = gates.hs_b;
    assign gate_ls_b_o = gates.ls_b;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
    parameter int DEAD_CYC = 1
) (
    input logic clk_i,
    input logic rst_n_i,
    input logic sleep_n_i,
    input logic therm_flt_i,
    input logic uv_flt_i,
    input logic hs_a,
    input logic ls_a,
    input logic hs_b,
    input logic ls_b
);
    localparam int GW = $clog2(DEAD_CYC + 1);

    logic [GW-1:0] gap_hs_a, gap_ls_a, gap_hs_b, gap_ls_b;

    function automatic logic [GW-1:0] bump(input logic on, input logic [GW-1:0] g);
        if (on) return '0;
        if (g < GW'(DEAD_CYC)) return g + 1'b1;
        return g;
    endfunction

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            gap_hs_a <= GW'(DEAD_CYC);
            gap_ls_a <= GW'(DEAD_CYC);
            gap_hs_b <= GW'(DEAD_CYC);
            gap_ls_b <= GW'(DEAD_CYC);
        end else begin
            gap_hs_a <= bump(hs_a, gap_hs_a);
            gap_ls_a <= bump(ls_a, gap_ls_a);
            gap_hs_b <= bump(hs_b, gap_hs_b);
            gap_ls_b <= bump(ls_b, gap_ls_b);
        end
    end

    AST_LEG_A_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i) !(hs_a && ls_a)); // R3
    AST_LEG_B_EXCL: assert property (@(posedge clk_i) disable iff (!rst_n_i) !(hs_b && ls_b)); // R3
    AST_HS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i) $onehot0({hs_a, hs_b})); // R1
    AST_GAP_LS_A: assert property (@(posedge clk_i) disable iff (!rst_n_i) $rose(ls_a) |-> gap_hs_a >= GW'(DEAD_CYC)); // R5
    AST_GAP_HS_A: assert property (@(posedge clk_i) disable iff (!rst_n_i) $rose(hs_a) |-> gap_ls_a >= GW'(DEAD_CYC)); // R5
    AST_GAP_LS_B: assert property (@(posedge clk_i) disable iff (!rst_n_i) $rose(ls_b) |-> gap_hs_b >= GW'(DEAD_CYC)); // R5
    AST_GAP_HS_B: assert property (@(posedge clk_i) disable iff (!rst_n_i) $rose(hs_b) |-> gap_ls_b >= GW'(DEAD_CYC)); // R5
    AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_i) (therm_flt_i || uv_flt_i) |=> !(hs_a || ls_a || hs_b || ls_b)); // R10
    AST_SLEEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_i) (!sleep_n_i && $past(!sleep_n_i) && $past(!sleep_n_i, 2)) |=> !(hs_a || ls_a || hs_b || ls_b)); // R8
endmodule

bind hbridge_chop_ctrl hbc_checker #(.DEAD_CYC(DEAD_CYC)) u_hbc_checker (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .sleep_n_i   (sleep_n_i),
    .therm_flt_i (therm_flt_i),
    .uv_flt_i    (uv_flt_i),
    .hs_a        (gate_hs_a_o),
    .ls_a        (gate_ls_a_o),
    .hs_b        (gate_hs_b_o),
    .ls_b        (gate_ls_b_o)
);

// File: tb/hbridge_chop_ctrl_bench.sv
module hbridge_chop_ctrl_bench;
    localparam int CLK_HZ = 200_000_000;
    localparam int OFF_C   = 40;
    localparam int BLANK_C = 20;
    localparam int DEAD_C  = 5;
    localparam int WAKE_C  = 200;

    logic clk = 1'b0;
    logic rst_n, dir_a, dir_b, sleep_n, trip, therm, uv;
    logic hs_a, ls_a, hs_b, ls_b;
    int   n_vec = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    hbridge_chop_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .OFF_NS   (OFF_C * 5),
        .BLANK_NS (BLANK_C * 5),
        .DEAD_NS  (DEAD_C * 5),
        .WAKE_NS  (WAKE_C * 5)
    ) u_hbridge_chop_ctrl (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .dir_a_i     (dir_a),
        .dir_b_i     (dir_b),
        .sleep_n_i   (sleep_n),
        .trip_i      (trip),
        .therm_flt_i (therm),
        .uv_flt_i    (uv),
        .gate_hs_a_o (hs_a),
        .gate_ls_a_o (ls_a),
        .gate_hs_b_o (hs_b),
        .gate_ls_b_o (ls_b)
    );

    // {dir_a, dir_b, hs_a, ls_a, hs_b, ls_b}
    localparam logic [5:0] VEC [0:7] = '{
        6'b10_1001, 6'b01_0110, 6'b11_0101, 6'b00_0000,
        6'b11_0101, 6'b10_1001, 6'b00_0000, 6'b01_0110
    };

    function automatic logic [3:0] gv();
        return {hs_a, ls_a, hs_b, ls_b};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        int m;
        int first_ls;
        int bad;
        rst_n = 0; dir_a = 0; dir_b = 0; sleep_n = 0;
        trip = 0; therm = 0; uv = 0;
        repeat (5) @(negedge clk);
        check("R11 gates under reset", gv(), 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R11 gates after reset, still asleep", gv(), 0);

        // R9 wake delay with forward already applied
        dir_a = 1;
        repeat (5) @(negedge clk);
        sleep_n = 1;
        @(negedge clk);
        n = 0;
        while (!hs_a) begin n++; @(negedge clk); end
        check("R9 cycles from release to first drive", n, WAKE_C + DEAD_C + 3);

        // R1 table walk
        for (int i = 0; i < 8; i++) begin
            dir_a = VEC[i][5];
            dir_b = VEC[i][4];
            repeat (30) @(negedge clk);
            check("R1 decoded gates", gv(), int'(VEC[i][3:0]));
        end

        // R4 / R5 single trip in forward
        dir_a = 1; dir_b = 0;
        repeat (30) @(negedge clk);
        check("R1 forward before trip", gv(), 9);
        trip = 1;
        @(negedge clk);
        trip = 0;
        n = 0; m = 0; first_ls = -1; bad = 0;
        while (!hs_a) begin
            if (ls_a) begin
                m++;
                if (first_ls < 0) first_ls = n;
            end
            if (!ls_b) bad++;
            n++;
            @(negedge clk);
        end
        check("R4 high-side off-time", n, OFF_C);
        check("R5 low-side A turn-on delay", first_ls, DEAD_C);
        check("R5 low-side A on duration", m, OFF_C - 2 * DEAD_C);
        check("R5 low-side B held during off-time", bad, 0);
        check("R4 diagonal restored", gv(), 9);

        // R6 trip held: on-time equals blank, then full off-time
        trip = 1;
        n = 0;
        while (hs_a) begin n++; @(negedge clk); end
        check("R6 on-time under held trip", n, BLANK_C);
        n = 0;
        while (!hs_a) begin n++; @(negedge clk); end
        check("R4 off-time under held trip", n, OFF_C);
        n = 0;
        while (hs_a) begin n++; @(negedge clk); end
        check("R6 second on-time under held trip", n, BLANK_C);
        trip = 0;
        while (!hs_a) @(negedge clk);

        // R6 short pulse inside blanking ignored
        repeat (3) @(negedge clk);
        trip = 1;
        @(negedge clk);
        trip = 0;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (!hs_a) n++;
            @(negedge clk);
        end
        check("R6 trip within blank ignored", n, 0);

        // R2 reversal latency and dead interval
        repeat (30) @(negedge clk);
        dir_a = 0; dir_b = 1;
        @(negedge clk);
        n = 0;
        while (hs_a) begin n++; @(negedge clk); end
        check("R2 synchronizer latency", n, 2);
        m = 0;
        while (gv() == 4'b0000) begin m++; @(negedge clk); end
        check("R2 all-off interval on reversal", m, DEAD_C);
        check("R2 reverse gates after dead", gv(), 6);

        // R7 brake ignores trip
        dir_a = 1; dir_b = 1;
        repeat (30) @(negedge clk);
        trip = 1;
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (gv() != 4'b0101) bad++;
        end
        trip = 0;
        check("R7 gate changes during brake trip", bad, 0);

        // R10 faults
        dir_a = 1; dir_b = 0;
        repeat (30) @(negedge clk);
        therm = 1;
        @(negedge clk);
        check("R10 thermal fault off next edge", gv(), 0);
        repeat (10) @(negedge clk);
        check("R10 thermal fault held off", gv(), 0);
        therm = 0; uv = 1;
        @(negedge clk);
        check("R10 undervoltage fault off", gv(), 0);
        uv = 0;
        repeat (30) @(negedge clk);
        check("R10 resume after faults clear", gv(), 9);

        // R8 sleep
        sleep_n = 0;
        repeat (2) @(negedge clk);
        check("R8 gates before sleep takes effect", gv(), 9);
        @(negedge clk);
        check("R8 gates off after third edge", gv(), 0);
        dir_a = 0; dir_b = 1;
        repeat (10) @(negedge clk);
        check("R8 commands ignored while asleep", gv(), 0);

        summary();
        $finish;
    end
endmodule